// File: doc/BRIEF.md
# Key Wrap Round Sequencer

This block runs the step loop of the 64-bit-semiblock key wrap algorithm, forward (wrap) and backward (unwrap). It keeps the integrity word A in a register. It fetches and stores the R words in an external single-port word memory, and it hands each 128-bit block to an external block cipher through a start/response port. The block itself holds no cipher, creates no integrity value and does no padding. The host must provide an object that is already a whole number of 64-bit words, together with its own initial A.

To start an operation the host presents the initial A, the word count n (not counting the integrity word), the key-length flag and the direction, then pulses `start` while `ready` is high. Every step reads R[i] from address i-1 and builds the block. The block then goes to the cipher. On the response, the lower half is written back to the same address and A is updated. A running counter t = n*j + i is mixed into A: after the cipher when wrapping, before the cipher when unwrapping. `ready` rises again after the final write.

The controller has five named states. IDLE: ready, waiting for start. READ: memory read issued. FETCH: read word captured. ISSUE: cipher start pulse. AWAIT: waiting for the cipher response. The named transitions are: T_START (IDLE to READ, start with n nonzero), T_EMPTY (IDLE to IDLE, start with n zero), READ to FETCH, FETCH to ISSUE, ISSUE to AWAIT, T_NEXT (AWAIT to READ, response and more steps left) and T_FINISH (AWAIT to IDLE, response on the last step).

Top module: `kw_round_seq`

## Requirements
- R1: After reset `ready` is 1, `a_out` is 0, and `cph_start`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: In wrap mode (`unwrap`=0) the block issues exactly 6n cipher requests. Their order is j ascending from 0 to 5 and, within each j, i ascending from 1 to n. Each request block is {A, R[i]}, with A in bits 127:64.
- R3: In wrap mode, after each response A becomes result[127:64] XOR t, where t = n*j + i is zero-extended to 64 bits. The final A appears on `a_out`.
- R4: Each response writes result[63:0] to memory address i-1, which holds R[i]. After the operation the memory holds the final R words.
- R5: In unwrap mode (`unwrap`=1) the block issues 6n requests. Their order is j descending from 5 to 0 and, within each j, i descending from n to 1. Each request block is {A XOR t, R[i]}.
- R6: In unwrap mode, after each response A becomes result[127:64]. Unwrapping the output of a wrap, with the same key and n, restores the original A and R words.
- R7: Every request carries `cph_decrypt` equal to the direction (1 = unwrap) and `cph_key256` equal to the key-length flag (1 = 256-bit key), both captured at start.
- R8: Only one cipher request is outstanding at a time. `cph_start` is not pulsed again until `cph_ready` has returned, and `cph_block` stays stable while a request is outstanding.
- R9: A start with n = 0 leaves `ready` at 1 and makes `a_out` equal to the supplied initial A. It issues no cipher request and writes no memory word.
- R10: `ready` is 0 from the cycle after an accepted start with nonzero n until the last write, and returns to 1 after it.
- R11: A `start` pulse while the block is busy is ignored. The running operation completes with its original inputs.
- R12: n up to MAX_BLOCKS (default 512) is supported, and t is wide enough that it never wraps (maximum 6*MAX_BLOCKS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when ready) |
| unwrap | input | 1 | Direction: 0 wrap, 1 unwrap |
| key_256 | input | 1 | Key length: 0 for 128-bit, 1 for 256-bit |
| n_blocks | input | LEN_W | Number of 64-bit R words, excluding the integrity word |
| a_init | input | 64 | Initial integrity word A |
| ready | output | 1 | Idle and result valid |
| a_out | output | 64 | Current integrity word A |
| mem_addr | output | LEN_W | Word address (i-1) for R[i] |
| mem_rd_en | output | 1 | Read request; data is expected one cycle later |
| mem_rdata | input | 64 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 64 | Write data |
| cph_start | output | 1 | One-cycle cipher request pulse |
| cph_decrypt | output | 1 | Request inverse cipher |
| cph_key256 | output | 1 | Key-length flag for the cipher |
| cph_block | output | 128 | Block sent to the cipher |
| cph_ready | input | 1 | One-cycle response valid, at least one cycle after the request |
| cph_result | input | 128 | Cipher result |

## Verification
The bench builds the block with its default parameters, MAX_BLOCKS = 512 and a 16-bit t. This makes a full-length 512-word object reachable, with t running up to 3072 in both directions. A keyed, invertible rotate-and-XOR permutation stands in for the cipher, and its response latency rotates between one and three cycles. The bench checks every request against a scoreboard of expected blocks and flags. The tests cover single-word, short and full-length objects, both key lengths, a wrap/unwrap round trip, the empty object and a start pulse during a run.

// File: rtl/kw_pkg.sv
package kw_pkg;

    localparam int SEMI_W = 64;
    localparam int BLK_W  = 2 * SEMI_W;
    localparam int PASSES = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_FETCH,
        ST_ISSUE,
        ST_AWAIT
    } kw_state_e;

endpackage

// File: rtl/kw_step_ctr.sv
module kw_step_ctr #(
    parameter int LEN_W = 10,
    parameter int T_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             unwrap_in,
    input  logic [LEN_W-1:0] n_in,
    output logic [LEN_W-1:0] idx,
    output logic [T_W-1:0]   t,
    output logic             last,
    output logic             dir_q,
    output logic             n_zero
);
    import kw_pkg::*;

    localparam logic [2:0] J_LAST = 3'(PASSES - 1);

    logic [LEN_W-1:0] n_q;
    logic [2:0]       j_q;
    logic [T_W-1:0]   n_ext;

    assign n_ext  = T_W'(n_in);
    assign n_zero = (n_in == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q   <= '0;
            j_q   <= '0;
            idx   <= '0;
            t     <= '0;
            dir_q <= 1'b0;
        end else if (load) begin
            n_q   <= n_in;
            dir_q <= unwrap_in;
            if (unwrap_in) begin
                j_q <= J_LAST;
                idx <= n_in;
                t   <= (n_ext << 2) + (n_ext << 1);
            end else begin
                j_q <= '0;
                idx <= LEN_W'(1);
                t   <= T_W'(1);
            end
        end else if (advance) begin
            if (dir_q) begin
                t <= t - T_W'(1);
                if (idx == LEN_W'(1)) begin
                    idx <= n_q;
                    j_q <= j_q - 3'd1;
                end else begin
                    idx <= idx - LEN_W'(1);
                end
            end else begin
                t <= t + T_W'(1);
                if (idx == n_q) begin
                    idx <= LEN_W'(1);
                    j_q <= j_q + 3'd1;
                end else begin
                    idx <= idx + LEN_W'(1);
                end
            end
        end
    end

    assign last = dir_q ? ((j_q == 3'd0) && (idx == LEN_W'(1)))
                        : ((j_q == J_LAST) && (idx == n_q));

endmodule

// File: rtl/kw_fsm.sv
module kw_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic n_zero,
    input  logic last,
    input  logic cph_ready,
    output logic load,
    output logic rd_en,
    output logic latch_r,
    output logic cph_start,
    output logic step,
    output logic ready
);
    import kw_pkg::*;

    kw_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start && !n_zero) state_nx = ST_READ;   // T_START; T_EMPTY stays
            ST_READ:  state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_AWAIT;
            ST_AWAIT: if (cph_ready) state_nx = last ? ST_IDLE : ST_READ; // T_FINISH / T_NEXT
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load      = 1'b0;
        rd_en     = 1'b0;
        latch_r   = 1'b0;
        cph_start = 1'b0;
        step      = 1'b0;
        ready     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready = 1'b1;
                load  = start;
            end
            ST_READ:  rd_en     = 1'b1;
            ST_FETCH: latch_r   = 1'b1;
            ST_ISSUE: cph_start = 1'b1;
            ST_AWAIT: step      = cph_ready;
            default:  ready     = 1'b0;
        endcase
    end

endmodule

// File: rtl/kw_datapath.sv
module kw_datapath #(
    parameter int T_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [kw_pkg::SEMI_W-1:0]   a_init,
    input  logic                        key_256,
    input  logic                        dir_q,
    input  logic                        latch_r,
    input  logic [kw_pkg::SEMI_W-1:0]   mem_rdata,
    input  logic                        step,
    input  logic [kw_pkg::BLK_W-1:0]    cph_result,
    input  logic [T_W-1:0]              t,
    output logic [kw_pkg::SEMI_W-1:0]   a_out,
    output logic [kw_pkg::SEMI_W-1:0]   mem_wdata,
    output logic [kw_pkg::BLK_W-1:0]    cph_block,
    output logic                        key_q
);
    import kw_pkg::*;

    logic [SEMI_W-1:0] a_q;
    logic [SEMI_W-1:0] r_q;
    logic [SEMI_W-1:0] t_ext;
    logic [SEMI_W-1:0] res_hi;

    assign t_ext  = {{(SEMI_W-T_W){1'b0}}, t};
    assign res_hi = cph_result[BLK_W-1:SEMI_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            r_q   <= '0;
            key_q <= 1'b0;
        end else begin
            if (load) begin
                a_q   <= a_init;
                key_q <= key_256;
            end else if (step) begin
                a_q <= dir_q ? res_hi : (res_hi ^ t_ext);
            end
            if (latch_r) r_q <= mem_rdata;
        end
    end

    assign cph_block = {(dir_q ? (a_q ^ t_ext) : a_q), r_q};
    assign mem_wdata = cph_result[SEMI_W-1:0];
    assign a_out     = a_q;

endmodule

// File: rtl/kw_round_seq.sv
module kw_round_seq #(
    parameter int MAX_BLOCKS = 512,
    parameter int T_W        = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              unwrap,
    input  logic                              key_256,
    input  logic [$clog2(MAX_BLOCKS+1)-1:0]   n_blocks,
    input  logic [63:0]                       a_init,
    output logic                              ready,
    output logic [63:0]                       a_out,
    output logic [$clog2(MAX_BLOCKS+1)-1:0]   mem_addr,
    output logic                              mem_rd_en,
    input  logic [63:0]                       mem_rdata,
    output logic                              mem_wr_en,
    output logic [63:0]                       mem_wdata,
    output logic                              cph_start,
    output logic                              cph_decrypt,
    output logic                              cph_key256,
    output logic [127:0]                      cph_block,
    input  logic                              cph_ready,
    input  logic [127:0]                      cph_result
);
    localparam int LEN_W = $clog2(MAX_BLOCKS + 1);

    logic             load, latch_r, step, last, dir_q, n_zero;
    logic [LEN_W-1:0] idx;
    logic [T_W-1:0]   t;

    kw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .n_zero    (n_zero),
        .last      (last),
        .cph_ready (cph_ready),
        .load      (load),
        .rd_en     (mem_rd_en),
        .latch_r   (latch_r),
        .cph_start (cph_start),
        .step      (step),
        .ready     (ready)
    );

    kw_step_ctr #(.LEN_W(LEN_W), .T_W(T_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (step),
        .unwrap_in (unwrap),
        .n_in      (n_blocks),
        .idx       (idx),
        .t         (t),
        .last      (last),
        .dir_q     (dir_q),
        .n_zero    (n_zero)
    );

    kw_datapath #(.T_W(T_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .a_init     (a_init),
        .key_256    (key_256),
        .dir_q      (dir_q),
        .latch_r    (latch_r),
        .mem_rdata  (mem_rdata),
        .step       (step),
        .cph_result (cph_result),
        .t          (t),
        .a_out      (a_out),
        .mem_wdata  (mem_wdata),
        .cph_block  (cph_block),
        .key_q      (cph_key256)
    );

    assign mem_addr    = idx - LEN_W'(1);
    assign mem_wr_en   = step;
    assign cph_decrypt = dir_q;

endmodule

// File: rtl/kw_round_seq_chk.sv
module kw_round_seq_chk #(
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] n_blocks,
    input logic             ready,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic             cph_start,
    input logic             cph_ready,
    input logic [127:0]     cph_block
);
    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pend <= 1'b0;
        else if (cph_start) pend <= 1'b1;
        else if (cph_ready) pend <= 1'b0;
    end

    // R8: no second request while one is outstanding
    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        cph_start |-> !pend);

    // R8: request block held while waiting
    a_r8_block_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cph_ready) |=> $stable(cph_block));

    // R4: memory written only on a cipher response
    a_r4_write_on_response: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (cph_ready && pend));

    // R4: read and write never in the same cycle
    a_r4_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R9: empty start keeps ready high
    a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && (n_blocks == '0)) |=> ready);

    // R10: accepted start drops ready
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && (n_blocks != '0)) |=> !ready);

    // R10: no request while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!cph_start && !mem_rd_en && !mem_wr_en));

endmodule

bind kw_round_seq kw_round_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .n_blocks  (n_blocks),
    .ready     (ready),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .cph_start (cph_start),
    .cph_ready (cph_ready),
    .cph_block (cph_block)
);

// File: tb/tb_kw_round_seq.sv
module tb_kw_round_seq;

    localparam int CLK_PERIOD = 10;
    localparam int MAXN       = 512;
    localparam int LW         = $clog2(MAXN + 1);

    typedef struct packed {
        logic [127:0] blk;
        logic         dec;
        logic         k256;
    } req_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          unwrap = 1'b0;
    logic          key_256 = 1'b0;
    logic [LW-1:0] n_blocks = '0;
    logic [63:0]   a_init = '0;
    logic          ready;
    logic [63:0]   a_out;
    logic [LW-1:0] mem_addr;
    logic          mem_rd_en;
    logic [63:0]   mem_rdata = '0;
    logic          mem_wr_en;
    logic [63:0]   mem_wdata;
    logic          cph_start;
    logic          cph_decrypt;
    logic          cph_key256;
    logic [127:0]  cph_block;
    logic          cph_ready = 1'b0;
    logic [127:0]  cph_result = '0;

    logic [63:0] mem   [0:MAXN-1];
    logic [63:0] ref_r [0:MAXN-1];
    logic [63:0] orig  [0:MAXN-1];
    req_t        exp_q[$];

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    kw_round_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .unwrap(unwrap), .key_256(key_256),
        .n_blocks(n_blocks), .a_init(a_init), .ready(ready), .a_out(a_out),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .cph_start(cph_start),
        .cph_decrypt(cph_decrypt), .cph_key256(cph_key256), .cph_block(cph_block),
        .cph_ready(cph_ready), .cph_result(cph_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] cip(input logic [127:0] x, input logic dec, input logic k256);
        logic [127:0] k1, k2, y;
        k1 = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
        k2 = k256 ? 128'h3141_5926_5358_9793_2384_6264_3383_2795
                  : 128'hDEAD_BEEF_0BAD_F00D_1234_5678_9ABC_DEF0;
        if (!dec) begin
            y = x ^ k1;
            y = {y[104:0], y[127:105]};
            return y ^ k2;
        end
        y = x ^ k2;
        y = {y[22:0], y[127:23]};
        return y ^ k1;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    end

    // cipher stand-in with rotating latency
    logic [127:0] h_blk;
    logic         h_dec, h_k, busy = 1'b0;
    int           cnt = 0, lat_sel = 0;
    always @(posedge clk) begin
        cph_ready <= 1'b0;
        if (cph_start) begin
            busy    <= 1'b1;
            cnt     <= lat_sel;
            lat_sel <= (lat_sel + 1) % 3;
            h_blk   <= cph_block;
            h_dec   <= cph_decrypt;
            h_k     <= cph_key256;
        end else if (busy) begin
            if (cnt == 0) begin
                cph_ready  <= 1'b1;
                cph_result <= cip(h_blk, h_dec, h_k);
                busy       <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    // monitor: compare each request with the scoreboard
    always @(negedge clk) begin
        if (rst_n && cph_start) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected request", 128'd1, 128'd0);
            end else begin
                req_t e;
                e = exp_q.pop_front();
                check(e.dec ? "R5 unwrap block" : "R2 wrap block", cph_block, e.blk);
                check("R7 direction flag", {127'd0, cph_decrypt}, {127'd0, e.dec});
                check("R7 key flag", {127'd0, cph_key256}, {127'd0, e.k256});
            end
        end
    end

    // driver: computes the expected sequence, then runs the block
    task automatic run_op(input bit uw, input bit k256, input int n,
                          input logic [63:0] a0, input bit poke, output logic [63:0] a_exp);
        logic [63:0]  a;
        logic [127:0] b, blk;
        logic [63:0]  t64;
        logic [63:0]  keep0;
        int           cyc;
        req_t         e;
        for (int k = 0; k < n; k++) ref_r[k] = mem[k];
        keep0 = mem[0];
        a = a0;
        if (!uw) begin
            for (int j = 0; j < 6; j++)
                for (int i = 1; i <= n; i++) begin
                    t64 = 64'(n * j + i);
                    blk = {a, ref_r[i-1]};
                    e.blk = blk; e.dec = 1'b0; e.k256 = k256;
                    exp_q.push_back(e);
                    b = cip(blk, 1'b0, k256);
                    a = b[127:64] ^ t64;
                    ref_r[i-1] = b[63:0];
                end
        end else begin
            for (int j = 5; j >= 0; j--)
                for (int i = n; i >= 1; i--) begin
                    t64 = 64'(n * j + i);
                    blk = {a ^ t64, ref_r[i-1]};
                    e.blk = blk; e.dec = 1'b1; e.k256 = k256;
                    exp_q.push_back(e);
                    b = cip(blk, 1'b1, k256);
                    a = b[127:64];
                    ref_r[i-1] = b[63:0];
                end
        end
        a_exp = a;
        @(negedge clk);
        start = 1'b1; unwrap = uw; key_256 = k256; n_blocks = LW'(n); a_init = a0;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            check("R9 ready stays high", {127'd0, ready}, 128'd1);
            check("R9 a_out equals initial A", a_out, a0);
            repeat (4) @(negedge clk);
            check("R9 memory untouched", mem[0], keep0);
            check("R9 no request queued", 128'(exp_q.size()), 128'd0);
            return;
        end
        check("R10 ready low when busy", {127'd0, ready}, 128'd0);
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; a_init = ~a0; n_blocks = LW'(1); unwrap = ~uw; key_256 = ~k256;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!ready && cyc < 100000) begin
            @(negedge clk);
            cyc++;
        end
        check("R10 ready after last step", {127'd0, ready}, 128'd1);
        check(uw ? "R6 final A" : (poke ? "R11 final A" : "R3 final A"), a_out, a_exp);
        for (int k = 0; k < n; k++)
            check(poke ? "R11 memory word" : "R4 memory word", mem[k], ref_r[k]);
        check(uw ? "R5 request count" : "R2 request count", 128'(exp_q.size()), 128'd0);
    endtask

    task automatic fill(input int n, input logic [63:0] seed);
        for (int k = 0; k < n; k++) begin
            mem[k]  = seed ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15);
            orig[k] = mem[k];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] ax, ay;
        for (int k = 0; k < MAXN; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 reset ready", {127'd0, ready}, 128'd1);
        check("R1 reset a_out", a_out, 128'd0);
        check("R1 reset quiet", {125'd0, cph_start, mem_rd_en, mem_wr_en}, 128'd0);

        // R2 R3 R4: single word, 128-bit key
        fill(1, 64'h1111_2222_3333_4444);
        run_op(1'b0, 1'b0, 1, 64'hA6A6_A6A6_A6A6_A6A6, 1'b0, ax);

        // R2 R3 R7: three words, 256-bit key, then unwrap round trip R6
        fill(3, 64'h0123_4567_89AB_CDEF);
        run_op(1'b0, 1'b1, 3, 64'hA6A6_A6A6_A6A6_A6A6, 1'b0, ax);
        run_op(1'b1, 1'b1, 3, a_out, 1'b0, ay);
        check("R6 round trip A", a_out, 64'hA6A6_A6A6_A6A6_A6A6);
        for (int k = 0; k < 3; k++) check("R6 round trip word", mem[k], orig[k]);

        // R5: unwrap of arbitrary data
        fill(2, 64'hFEDC_BA98_7654_3210);
        run_op(1'b1, 1'b0, 2, 64'h5555_AAAA_0F0F_F0F0, 1'b0, ay);

        // R9: empty object
        mem[0] = 64'hCAFE_F00D_CAFE_F00D;
        run_op(1'b0, 1'b0, 0, 64'h0BAD_CAFE_1234_9876, 1'b0, ay);

        // R11: start during run ignored
        fill(4, 64'h7777_0000_7777_0000);
        run_op(1'b0, 1'b1, 4, 64'h1357_9BDF_2468_ACE0, 1'b1, ax);

        // R12: full length, both directions
        fill(MAXN, 64'h2B7E_1516_28AE_D2A6);
        run_op(1'b0, 1'b0, MAXN, 64'hA6A6_A6A6_A6A6_A6A6, 1'b0, ax);
        check("R12 full-length wrap A", a_out, ax);
        run_op(1'b1, 1'b0, MAXN, a_out, 1'b0, ay);
        check("R12 full-length round trip A", a_out, 64'hA6A6_A6A6_A6A6_A6A6);
        for (int k = 0; k < MAXN; k++) check("R12 round trip word", mem[k], orig[k]);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule